// File: doc/BRIEF.md
# Sliding-Window Template Occurrence Feature Unit

This block turns a stream of template-match events into normalised feature vectors for a downstream pattern classifier. Each event names the template that an incoming spike matched. The block counts events per template within the current block of samples. At every block boundary it moves those counts into a circular store of the most recent `N_BLK` block columns, one column per block. It then sums each template's counts over the stored columns. This gives a sliding window of `N_BLK` blocks without keeping any raw samples.

After each boundary the block divides every windowed template count by the total number of spikes in the window, which is the window's spikeness. A sequential restoring divider performs the divisions one template at a time. The block then presents the fractions together with the spikeness. When the window holds no spikes, the pattern is marked invalid. During labelled training a pattern is passed on only if its spikeness reaches a threshold. The threshold is built from a mean and a standard deviation that the caller supplies at the boundary. Boundaries must be spaced further apart than one full feature computation, which takes about `N_TPL*(FEAT_W+3)` cycles.

Top module: `occ_feat_win`

## Requirements
- R1: While reset is held and after it is released, `pat_vld_o`, `pat_ok_o`, `pat_fwd_o`, `spk_o` and `feat_o` are all zero until the first pattern completes.
- R2: A cycle with `match_vld_i` high and `match_idx_i` = t < `N_TPL` adds one to template t's count for the current block. An index of `N_TPL` or above changes no count.
- R3: At a cycle with `blk_end_i` high, the current block's counts replace the oldest of the `N_BLK` stored columns. The window for the pattern that follows is therefore the sum over the last `N_BLK` completed blocks, including the block that has just ended.
- R4: A match arriving in the same cycle as `blk_end_i` is counted into the block that begins there. Every other count of the new block starts at zero.
- R5: `spk_o` is the sum of all windowed counts. Feature t sits at `feat_o[16t+15:16t]` as unsigned Q0.16 and equals min(floor(W_t·65536/`spk_o`), 65535), where W_t is template t's windowed count.
- R6: When the window total is zero, all features are zero and both `pat_ok_o` and `pat_fwd_o` are 0. Otherwise `pat_ok_o` is 1.
- R7: Each block boundary yields exactly one single-cycle `pat_vld_o` pulse. `feat_o`, `spk_o`, `pat_ok_o` and `pat_fwd_o` change only on that pulse and hold their values until the next one.
- R8: `train_i`, `spk_mean_i` and `spk_sd_i` are sampled in the boundary cycle. `pat_fwd_o` = `pat_ok_o` AND (NOT train OR `spk_o` ≥ mean + floor(sd/2)).
- R9: A per-block template count saturates at 2^`CNT_W`−1. Matches beyond that in the same block are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_vld_i | input | 1 | Template match event |
| match_idx_i | input | IDX_W | Index of the matched template |
| blk_end_i | input | 1 | Closes the current block |
| train_i | input | 1 | Labelled training active, sampled at boundary |
| spk_mean_i | input | TOT_W | Mean spikeness for the training gate |
| spk_sd_i | input | TOT_W | Spikeness standard deviation for the gate |
| pat_vld_o | output | 1 | Pattern complete pulse |
| pat_ok_o | output | 1 | Window held at least one spike |
| pat_fwd_o | output | 1 | Pattern passes the training gate |
| spk_o | output | TOT_W | Window spike total |
| feat_o | output | N_TPL*FEAT_W | Q0.16 feature per template |

## Verification
The bench uses a five-template, three-block, 4-bit-count configuration. It drives hand-built count patterns whose fractions differ per template, so a wrong column or a wrong divider bit changes a specific element. A sequence of boundaries checks that the oldest column leaves the window at the right step. Matches that coincide with a boundary separate "counted into the new block" from "counted into the old block". Out-of-range indices, saturating bursts, empty windows and a window filled by a single template push on the ignore, clamp, invalid and 1.0 cases. Gate probes place the threshold just above, exactly at and below the spikeness, and a randomised sweep checks the divider against arithmetic in the bench.

// File: rtl/occ_feat_pkg.sv
package occ_feat_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_DIV  = 2'd1,
    SQ_DONE = 2'd2
  } sq_state_e;
endpackage

// File: rtl/occ_cnt_mat.sv
module occ_cnt_mat #(
  parameter int N_TPL = 10,
  parameter int N_BLK = 4,
  parameter int CNT_W = 8,
  parameter int IDX_W = 4,
  parameter int WIN_W = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        match_vld_i,
  input  logic [IDX_W-1:0]            match_idx_i,
  input  logic                        blk_end_i,
  output logic [N_TPL-1:0][WIN_W-1:0] win_o
);
  localparam int PTR_W = (N_BLK > 1) ? $clog2(N_BLK) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PTR_W-1:0] wp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wp_q <= '0;
    else if (blk_end_i) wp_q <= (wp_q == PTR_W'(N_BLK - 1)) ? '0 : wp_q + 1'b1;
  end

  for (genvar t = 0; t < N_TPL; t++) begin : g_tpl
    logic             hit;
    logic [CNT_W-1:0] cur_q;
    logic [CNT_W-1:0] col_q [N_BLK];
    logic [CNT_W-1:0] old;
    logic [WIN_W-1:0] win_q;

    assign hit = match_vld_i && (match_idx_i == IDX_W'(t));
    assign old = col_q[wp_q];

    // column leaving the window is swapped for the block just closed
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cur_q <= '0;
        win_q <= '0;
      end else if (blk_end_i) begin
        win_q <= win_q - WIN_W'(old) + WIN_W'(cur_q);
        cur_q <= hit ? CNT_W'(1) : '0;
      end else if (hit && cur_q != CNT_MAX) begin
        cur_q <= cur_q + 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int b = 0; b < N_BLK; b++) col_q[b] <= '0;
      end else if (blk_end_i) begin
        for (int b = 0; b < N_BLK; b++)
          if (wp_q == PTR_W'(b)) col_q[b] <= cur_q;
      end
    end

    assign win_o[t] = win_q;
  end
endmodule

// File: rtl/occ_q16_div.sv
module occ_q16_div #(
  parameter int DEN_W  = 12,
  parameter int FEAT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DEN_W-1:0]  num_i,
  input  logic [DEN_W-1:0]  den_i,
  output logic              done_o,
  output logic [FEAT_W-1:0] quo_o
);
  localparam int QN    = FEAT_W + 1;
  localparam int CNT_W = $clog2(QN + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   rem_q;
  logic [DEN_W-1:0] den_q;
  logic [QN-1:0]    q_q;
  logic [DEN_W:0]   trial;
  logic             ge;

  // first step yields the integer bit without a shift
  assign trial = (cnt_q == '0) ? rem_q : {rem_q[DEN_W-1:0], 1'b0};
  assign ge    = trial >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      q_q    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        rem_q  <= {1'b0, num_i};
        den_q  <= den_i;
        q_q    <= '0;
      end else if (busy_q) begin
        q_q   <= {q_q[QN-2:0], ge};
        rem_q <= ge ? trial - {1'b0, den_q} : trial;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(QN - 1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quo_o = q_q[QN-1] ? '1 : q_q[FEAT_W-1:0];
endmodule

// File: rtl/occ_feat_win.sv
module occ_feat_win
  import occ_feat_pkg::*;
#(
  parameter int N_TPL  = 10,
  parameter int N_BLK  = 4,
  parameter int CNT_W  = 8,
  parameter int FEAT_W = 16,
  localparam int IDX_W = (N_TPL > 1) ? $clog2(N_TPL) : 1,
  localparam int WIN_W = CNT_W + ((N_BLK > 1) ? $clog2(N_BLK) : 0),
  localparam int TOT_W = WIN_W + ((N_TPL > 1) ? $clog2(N_TPL) : 0)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      match_vld_i,
  input  logic [IDX_W-1:0]          match_idx_i,
  input  logic                      blk_end_i,
  input  logic                      train_i,
  input  logic [TOT_W-1:0]          spk_mean_i,
  input  logic [TOT_W-1:0]          spk_sd_i,
  output logic                      pat_vld_o,
  output logic                      pat_ok_o,
  output logic                      pat_fwd_o,
  output logic [TOT_W-1:0]          spk_o,
  output logic [N_TPL*FEAT_W-1:0]   feat_o
);
  logic [N_TPL-1:0][WIN_W-1:0]  win;
  logic [TOT_W-1:0]             tot;
  logic                         blk_q;
  logic                         train_q;
  logic [TOT_W:0]               thr_q;
  sq_state_e                    st_q;
  logic [N_TPL-1:0][WIN_W-1:0]  snap_q;
  logic [TOT_W-1:0]             tot_q;
  logic [IDX_W-1:0]             t_q;
  logic                         div_go_q;
  logic                         div_done;
  logic [FEAT_W-1:0]            quo;
  logic [N_TPL-1:0][FEAT_W-1:0] acc_q;

  occ_cnt_mat #(
    .N_TPL(N_TPL), .N_BLK(N_BLK), .CNT_W(CNT_W), .IDX_W(IDX_W), .WIN_W(WIN_W)
  ) mat_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .match_vld_i(match_vld_i),
    .match_idx_i(match_idx_i),
    .blk_end_i  (blk_end_i),
    .win_o      (win)
  );

  always_comb begin
    tot = '0;
    for (int t = 0; t < N_TPL; t++) tot = tot + TOT_W'(win[t]);
  end

  occ_q16_div #(.DEN_W(TOT_W), .FEAT_W(FEAT_W)) div_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_go_q),
    .num_i  (TOT_W'(snap_q[t_q])),
    .den_i  (tot_q),
    .done_o (div_done),
    .quo_o  (quo)
  );

  // gate inputs captured with the boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q   <= 1'b0;
      train_q <= 1'b0;
      thr_q   <= '0;
    end else begin
      blk_q <= blk_end_i;
      if (blk_end_i) begin
        train_q <= train_i;
        thr_q   <= {1'b0, spk_mean_i} + (TOT_W + 1)'(spk_sd_i >> 1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= SQ_IDLE;
      snap_q    <= '0;
      tot_q     <= '0;
      t_q       <= '0;
      div_go_q  <= 1'b0;
      acc_q     <= '0;
      pat_vld_o <= 1'b0;
      pat_ok_o  <= 1'b0;
      pat_fwd_o <= 1'b0;
      spk_o     <= '0;
      feat_o    <= '0;
    end else begin
      div_go_q  <= 1'b0;
      pat_vld_o <= 1'b0;
      if (blk_q) begin
        snap_q <= win;
        tot_q  <= tot;
        acc_q  <= '0;
        t_q    <= '0;
        if (tot == '0) begin
          st_q <= SQ_DONE;
        end else begin
          st_q     <= SQ_DIV;
          div_go_q <= 1'b1;
        end
      end else begin
        unique case (st_q)
          SQ_DIV: if (div_done) begin
            acc_q[t_q] <= quo;
            if (t_q == IDX_W'(N_TPL - 1)) begin
              st_q <= SQ_DONE;
            end else begin
              t_q      <= t_q + 1'b1;
              div_go_q <= 1'b1;
            end
          end
          SQ_DONE: begin
            feat_o    <= acc_q;
            spk_o     <= tot_q;
            pat_ok_o  <= tot_q != '0;
            pat_fwd_o <= (tot_q != '0) && (!train_q || ({1'b0, tot_q} >= thr_q));
            pat_vld_o <= 1'b1;
            st_q      <= SQ_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/occ_feat_win_chk.sv
module occ_feat_win_chk #(
  parameter int N_TPL  = 10,
  parameter int N_BLK  = 4,
  parameter int CNT_W  = 8,
  parameter int FEAT_W = 16,
  localparam int WIN_W = CNT_W + ((N_BLK > 1) ? $clog2(N_BLK) : 0),
  localparam int TOT_W = WIN_W + ((N_TPL > 1) ? $clog2(N_TPL) : 0)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    pat_vld_o,
  input logic                    pat_ok_o,
  input logic                    pat_fwd_o,
  input logic [TOT_W-1:0]        spk_o,
  input logic [N_TPL*FEAT_W-1:0] feat_o
);
  localparam logic [31:0] ONE = 32'(1) << FEAT_W;
  logic [31:0] fsum;

  always_comb begin
    fsum = '0;
    for (int t = 0; t < N_TPL; t++) fsum = fsum + 32'(feat_o[t*FEAT_W +: FEAT_W]);
  end

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_vld_o |=> !pat_vld_o); // R7

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pat_vld_o |-> ($stable(feat_o) && $stable(spk_o) && $stable(pat_ok_o) && $stable(pat_fwd_o))); // R7

  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_vld_o && !pat_ok_o) |-> (feat_o == '0 && spk_o == '0 && !pat_fwd_o)); // R6

  AST_FWD_NEEDS_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_vld_o && pat_fwd_o) |-> pat_ok_o); // R8

  AST_FEAT_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pat_vld_o && pat_ok_o) |-> (fsum <= ONE && fsum + 32'(N_TPL) >= ONE)); // R5
endmodule

bind occ_feat_win occ_feat_win_chk #(
  .N_TPL(N_TPL), .N_BLK(N_BLK), .CNT_W(CNT_W), .FEAT_W(FEAT_W)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pat_vld_o(pat_vld_o),
  .pat_ok_o (pat_ok_o),
  .pat_fwd_o(pat_fwd_o),
  .spk_o    (spk_o),
  .feat_o   (feat_o)
);

// File: tb/occ_feat_win_tb_top.sv
module occ_feat_win_tb_top;
  localparam int NT = 5;
  localparam int NB = 3;
  localparam int CW = 4;
  localparam int FW = 16;
  localparam int IW = 3;
  localparam int TW = 9;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic match_vld_i = 1'b0;
  logic [IW-1:0] match_idx_i = '0;
  logic blk_end_i = 1'b0;
  logic train_i = 1'b0;
  logic [TW-1:0] spk_mean_i = '0;
  logic [TW-1:0] spk_sd_i = '0;
  logic pat_vld_o, pat_ok_o, pat_fwd_o;
  logic [TW-1:0] spk_o;
  logic [NT*FW-1:0] feat_o;

  always #4 clk = ~clk;

  occ_feat_win #(.N_TPL(NT), .N_BLK(NB), .CNT_W(CW), .FEAT_W(FW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .match_vld_i(match_vld_i), .match_idx_i(match_idx_i),
    .blk_end_i(blk_end_i), .train_i(train_i), .spk_mean_i(spk_mean_i), .spk_sd_i(spk_sd_i),
    .pat_vld_o(pat_vld_o), .pat_ok_o(pat_ok_o), .pat_fwd_o(pat_fwd_o),
    .spk_o(spk_o), .feat_o(feat_o)
  );

  int errs = 0;
  int checks = 0;
  int vcnt = 0;
  int nbound = 0;
  int cyc = 0;
  int cur[NT];
  int col[NB][NT];
  int wp = 0;

  always @(negedge clk) if (pat_vld_o) vcnt++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic do_match(input int idx);
    match_vld_i = 1'b1;
    match_idx_i = IW'(idx);
    @(negedge clk);
    match_vld_i = 1'b0;
    if (idx < NT && cur[idx] < CMAX) cur[idx]++;
  endtask

  // closes a block, waits for the pattern and checks it against the model
  task automatic do_bound(input string req, input bit with_m, input int midx,
                          input bit tr, input int mean, input int sd);
    int w[NT];
    int s;
    int thr;
    bit got;
    blk_end_i   = 1'b1;
    match_vld_i = with_m;
    match_idx_i = IW'(midx);
    train_i     = tr;
    spk_mean_i  = TW'(mean);
    spk_sd_i    = TW'(sd);
    @(negedge clk);
    blk_end_i   = 1'b0;
    match_vld_i = 1'b0;
    train_i     = 1'b0;
    nbound++;
    for (int t = 0; t < NT; t++) col[wp][t] = cur[t];
    wp = (wp + 1) % NB;
    for (int t = 0; t < NT; t++) cur[t] = 0;
    if (with_m && midx < NT) cur[midx] = 1;
    s = 0;
    for (int t = 0; t < NT; t++) begin
      w[t] = 0;
      for (int b = 0; b < NB; b++) w[t] += col[b][t];
      s += w[t];
    end
    got = 1'b0;
    for (int i = 0; i < 2000 && !got; i++) begin
      if (pat_vld_o) got = 1'b1;
      else @(negedge clk);
    end
    chk(got, {req, " pattern pulse"}, got, 1);
    if (!got) return;
    chk(spk_o == TW'(s), {req, " spk"}, spk_o, s);
    chk(pat_ok_o == (s != 0), {req, " R6 ok"}, pat_ok_o, s != 0);
    thr = mean + sd / 2;
    chk(pat_fwd_o == ((s != 0) && (!tr || s >= thr)), {req, " R8 fwd"}, pat_fwd_o,
        (s != 0) && (!tr || s >= thr));
    for (int t = 0; t < NT; t++) begin
      longint e;
      e = (s == 0) ? 0 : (longint'(w[t]) * 65536) / s;
      if (e > 65535) e = 65535;
      chk(feat_o[t*FW +: FW] == FW'(e), {req, " R5 feature"}, feat_o[t*FW +: FW], e);
    end
  endtask

  initial begin
    logic [NT*FW-1:0] held;
    logic [TW-1:0] held_s;
    for (int t = 0; t < NT; t++) begin
      cur[t] = 0;
      for (int b = 0; b < NB; b++) col[b][t] = 0;
    end
    repeat (3) @(negedge clk);
    chk(pat_vld_o == 0 && pat_ok_o == 0 && pat_fwd_o == 0, "R1 flags in reset",
        {pat_vld_o, pat_ok_o, pat_fwd_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(feat_o == '0 && spk_o == '0 && pat_vld_o == 0, "R1 outputs after reset",
        spk_o, 0);

    // R2: basic counts
    repeat (3) do_match(0);
    do_match(1);
    repeat (2) do_match(3);
    do_bound("R2 R3 first block", 0, 0, 0, 0, 0);

    // R7: outputs hold while counting proceeds
    held = feat_o; held_s = spk_o;
    repeat (4) do_match(2);
    repeat (5) @(negedge clk);
    chk(feat_o == held && spk_o == held_s && !pat_vld_o, "R7 hold between patterns",
        spk_o, held_s);

    // R2: out-of-range indices are ignored
    do_match(5); do_match(6); do_match(7);
    do_bound("R2 ignore idx", 0, 0, 0, 0, 0);

    // R4: same-cycle match goes into the new block
    do_match(1);
    do_bound("R4 same cycle", 1, 4, 0, 0, 0);
    do_bound("R4 R3 next block", 0, 0, 0, 0, 0);
    do_bound("R3 oldest dropped", 0, 0, 0, 0, 0);

    // R9: saturation
    repeat (20) do_match(2);
    do_bound("R9 saturate", 0, 0, 0, 0, 0);

    // R6: empty window
    repeat (3) do_bound("R6 empty", 0, 0, 0, 0, 0);

    // R5: single template gives clamped 1.0
    repeat (5) do_match(3);
    do_bound("R5 single", 0, 0, 0, 0, 0);

    // R8: gate around a steady spikeness of 6
    for (int k = 0; k < 3; k++) begin
      repeat (2) do_match(0);
      do_bound("R8 fill", 0, 0, 0, 0, 0);
    end
    repeat (2) do_match(0);
    do_bound("R8 thr below", 0, 0, 1, 5, 1);
    repeat (2) do_match(0);
    do_bound("R8 thr equal", 0, 0, 1, 5, 3);
    repeat (2) do_match(0);
    do_bound("R8 thr above", 0, 0, 1, 6, 2);
    repeat (2) do_match(0);
    do_bound("R8 untrained", 0, 0, 0, 40, 9);

    // randomised sweep
    for (int k = 0; k < 40; k++) begin
      int n;
      n = $urandom_range(0, 14);
      for (int j = 0; j < n; j++) do_match($urandom_range(0, 7));
      do_bound("R3 R5 sweep", $urandom_range(0, 1), $urandom_range(0, 7),
               $urandom_range(0, 1), $urandom_range(0, 40), $urandom_range(0, 20));
    end

    repeat (5) @(negedge clk);
    chk(vcnt == nbound, "R7 one pulse per boundary", vcnt, nbound);
    finish_run();
  end
endmodule